// File: doc/BRIEF.md
# Mode-Dependent Port Pin Multiplexer

This block controls an eight-pin I/O port. It holds a direction register that software can only write. For each pin it decides whether the pin is a plain input, a plain output, or a dedicated function. The dedicated functions are a system clock output, a bus-control strobe, an open-drain I2C data line, and a wait-request input.

The choice per pin comes from several inputs:
- the direction bits;
- an expanded-bus enable;
- a bus-width select;
- a two-bit wait-mode setting.

The operating mode is sampled only while reset is held, and it chooses the value the direction register starts from.

The block drives per-pin output-enable and output-value lines toward the pads. It also returns a read-back byte built from pad levels and port data bits. The bus controller, I2C engine and clock generator sit outside it and supply only their drive signals.

Top module: `pin_port_mux`

## Requirements
- R1: Reset is synchronous and active-low. While `rst_n` is low at a rising edge, the direction register loads 8'h40 when `mode_sel` is 2'd1, and 8'h00 for any other mode value.
- R2: A rising edge with `dir_we` high stores `dir_wdata` in the direction register, where bit i set means pin i is an output. With `exp_en` low, `pad_oe` equals the direction register from the cycle after the write.
- R3: With `exp_en` low, a pin whose direction bit is set drives its `port_dout` bit, except pin 6, which drives `clk_src`. Every pin whose output enable is low has `pad_out` 0.
- R4: With `exp_en` high, pins 5, 4 and 3 have output enable 1 whatever their direction bits say. They drive `bus_strobe[3]`, `bus_strobe[2]` and `bus_strobe[1]` respectively.
- R5: With `exp_en` high, pin 0 depends on `bus_wide`:
  - when `bus_wide` is 0, the pin is forced to drive `bus_strobe[0]`;
  - when `bus_wide` is 1, it is plain GPIO under direction bit 0.
- R6: With `exp_en` high, pins 2 and 1 remain plain GPIO under their direction bits. Pin 6 drives `clk_src` when bit 6 is set and is an input otherwise.
- R7: With `exp_en` high, pin 7 depends on `wait_mode`:
  - 2'b00 or 2'b11: GPIO;
  - 2'b01: wait input;
  - 2'b10: I2C data.

  With `exp_en` low, `wait_mode` has no effect and pin 7 is GPIO.
- R8: As I2C data, pin 7 is open-drain. Output enable 7 equals `i2c_sda_low` and `pad_out[7]` is 0.
- R9: As the wait input, pin 7 has output enable 0, and `wait_req` equals `pad_in[7]`. In every other configuration `wait_req` is 0.
- R10: `port_rdata` bit i returns the `port_dout` bit for a pin that is GPIO with its direction bit set. For every other pin (input, clock, strobe, I2C, wait) it returns `pad_in` bit i.
- R11: Changes of `mode_sel` outside reset, and of `dir_wdata` without `dir_we`, leave the direction register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Operating mode, sampled during reset |
| exp_en | input | 1 | Expanded-bus enable |
| bus_wide | input | 1 | Bus-width select (0 gives pin 0 to the bus strobe) |
| wait_mode | input | 2 | Pin 7 role in expanded operation |
| dir_we | input | 1 | Direction register write strobe |
| dir_wdata | input | 8 | Direction register write data |
| port_dout | input | 8 | Port data-out bits |
| clk_src | input | 1 | System clock to be driven on pin 6 |
| bus_strobe | input | 4 | Strobes for pins 0, 3, 4, 5 (bits 0..3) |
| i2c_sda_low | input | 1 | I2C engine pulls the data line low |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| port_rdata | output | 8 | Port read-back value |
| wait_req | output | 1 | Wait request taken from pin 7 |

## Verification
The configurations that are hardest to reach from the ports are the two special roles of pin 7 and the mode-1 start value.
- The wait-input and open-drain roles of pin 7 exist only when the expanded enable and a particular wait-mode code are applied together. The stimulus sets a GPIO output direction on pin 7 first, so that the forced release or the open-drain drive is visible. It then toggles `pad_in[7]` and `i2c_sda_low` within each setting.
- The mode-1 start value can be seen only through a reset with `mode_sel` held at 1. It is read through `pad_oe` in single-chip operation, before any write. A later change of `mode_sel` with no reset has to leave that pattern in place.

// File: rtl/pin_port_mux_pkg.sv
package pin_port_mux_pkg;

    typedef enum logic [2:0] {
        FN_GPIO,
        FN_CLKOUT,
        FN_STROBE,
        FN_SDA,
        FN_WAIT
    } pin_fn_e;

    localparam logic [1:0] MODE_ONE = 2'd1;
    localparam logic [1:0] WM_WAIT  = 2'b01;
    localparam logic [1:0] WM_SDA   = 2'b10;

    localparam int PIN_CLK  = 6;
    localparam int PIN_SDA  = 7;
    localparam int PIN_NARROW = 0;
    localparam int PIN_STRB_LO = 3;
    localparam int PIN_STRB_HI = 5;

endpackage

// File: rtl/ppm_dir_reg.sv
module ppm_dir_reg
    import pin_port_mux_pkg::*;
#(
    parameter int          W        = 8,
    parameter logic [W-1:0] RST_M1   = 8'h40,
    parameter logic [W-1:0] RST_REST = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_sel,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= (mode_sel == MODE_ONE) ? RST_M1 : RST_REST;
        end else if (we) begin
            dir <= wdata;
        end
    end

endmodule

// File: rtl/ppm_fn_decode.sv
module ppm_fn_decode
    import pin_port_mux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         exp_en,
    input  logic         bus_wide,
    input  logic [1:0]   wait_mode,
    input  logic [W-1:0] dir,
    output pin_fn_e      fn [W]
);

    always_comb begin
        for (int i = 0; i < W; i++) begin
            fn[i] = FN_GPIO;
            if (i == PIN_CLK && dir[i]) begin
                fn[i] = FN_CLKOUT;
            end
            if (exp_en) begin
                if (i >= PIN_STRB_LO && i <= PIN_STRB_HI) begin
                    fn[i] = FN_STROBE;
                end
                if (i == PIN_NARROW && !bus_wide) begin
                    fn[i] = FN_STROBE;
                end
                if (i == PIN_SDA) begin
                    unique case (wait_mode)
                        WM_WAIT: fn[i] = FN_WAIT;
                        WM_SDA:  fn[i] = FN_SDA;
                        default: fn[i] = FN_GPIO;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/ppm_pin_drive.sv
module ppm_pin_drive
    import pin_port_mux_pkg::*;
(
    input  pin_fn_e fn,
    input  logic    dir_bit,
    input  logic    dout_bit,
    input  logic    clk_src,
    input  logic    strobe_bit,
    input  logic    sda_low,
    input  logic    pad_bit,
    output logic    oe,
    output logic    out,
    output logic    rd,
    output logic    wait_bit
);

    always_comb begin
        oe       = 1'b0;
        out      = 1'b0;
        rd       = pad_bit;
        wait_bit = 1'b0;
        unique case (fn)
            FN_GPIO: begin
                oe  = dir_bit;
                out = dir_bit & dout_bit;
                rd  = dir_bit ? dout_bit : pad_bit;
            end
            FN_CLKOUT: begin
                oe  = 1'b1;
                out = clk_src;
            end
            FN_STROBE: begin
                oe  = 1'b1;
                out = strobe_bit;
            end
            FN_SDA: begin
                oe  = sda_low;
                out = 1'b0;
            end
            FN_WAIT: begin
                wait_bit = pad_bit;
            end
            default: begin
                oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pin_port_mux.sv
module pin_port_mux
    import pin_port_mux_pkg::*;
#(
    parameter int          W        = 8,
    parameter logic [W-1:0] RST_M1   = 8'h40,
    parameter logic [W-1:0] RST_REST = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_sel,
    input  logic         exp_en,
    input  logic         bus_wide,
    input  logic [1:0]   wait_mode,
    input  logic         dir_we,
    input  logic [W-1:0] dir_wdata,
    input  logic [W-1:0] port_dout,
    input  logic         clk_src,
    input  logic [3:0]   bus_strobe,
    input  logic         i2c_sda_low,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] port_rdata,
    output logic         wait_req
);

    logic [W-1:0] dir;
    logic [W-1:0] strb_vec;
    logic [W-1:0] wait_vec;
    pin_fn_e      fn [W];

    ppm_dir_reg #(.W(W), .RST_M1(RST_M1), .RST_REST(RST_REST)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .we       (dir_we),
        .wdata    (dir_wdata),
        .dir      (dir)
    );

    ppm_fn_decode #(.W(W)) u_dec (
        .exp_en    (exp_en),
        .bus_wide  (bus_wide),
        .wait_mode (wait_mode),
        .dir       (dir),
        .fn        (fn)
    );

    always_comb begin
        strb_vec = '0;
        strb_vec[PIN_NARROW] = bus_strobe[0];
        for (int k = PIN_STRB_LO; k <= PIN_STRB_HI; k++) begin
            strb_vec[k] = bus_strobe[k - PIN_STRB_LO + 1];
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_pin
        ppm_pin_drive u_drv (
            .fn         (fn[g]),
            .dir_bit    (dir[g]),
            .dout_bit   (port_dout[g]),
            .clk_src    (clk_src),
            .strobe_bit (strb_vec[g]),
            .sda_low    (i2c_sda_low),
            .pad_bit    (pad_in[g]),
            .oe         (pad_oe[g]),
            .out        (pad_out[g]),
            .rd         (port_rdata[g]),
            .wait_bit   (wait_vec[g])
        );
    end

    assign wait_req = |wait_vec;

endmodule

// File: rtl/pin_port_mux_chk.sv
module pin_port_mux_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         exp_en,
    input logic [1:0]   wait_mode,
    input logic         dir_we,
    input logic [W-1:0] dir_wdata,
    input logic         i2c_sda_low,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] port_rdata,
    input logic         wait_req
);

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> (exp_en || pad_oe == $past(dir_wdata)));

    // R11
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_we && !exp_en) |=> (exp_en || pad_oe == $past(pad_oe)));

    // R4
    strobe_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_en |-> (pad_oe[5:3] == 3'b111));

    // R8
    sda_open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_en && wait_mode == 2'b10) |-> (pad_oe[7] == i2c_sda_low && !pad_out[7]));

    // R9
    wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exp_en && wait_mode == 2'b01) |-> !wait_req);

    // R9
    wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_en && wait_mode == 2'b01) |-> (!pad_oe[7] && wait_req == pad_in[7]));

    // R10
    strobe_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_en |-> (port_rdata[5:3] == pad_in[5:3]));

endmodule

bind pin_port_mux pin_port_mux_chk #(.W(W)) u_chk (.*);

// File: tb/test_pin_port_mux.sv
module test_pin_port_mux;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic       exp_en;
    logic       bus_wide;
    logic [1:0] wait_mode;
    logic       dir_we;
    logic [7:0] dir_wdata;
    logic [7:0] port_dout;
    logic       clk_src;
    logic [3:0] bus_strobe;
    logic       i2c_sda_low;
    logic [7:0] pad_in;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [7:0] port_rdata;
    logic       wait_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pin_port_mux i_pin_port_mux (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .exp_en(exp_en),
        .bus_wide(bus_wide), .wait_mode(wait_mode), .dir_we(dir_we),
        .dir_wdata(dir_wdata), .port_dout(port_dout), .clk_src(clk_src),
        .bus_strobe(bus_strobe), .i2c_sda_low(i2c_sda_low), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .port_rdata(port_rdata),
        .wait_req(wait_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        mode_sel = m;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic write_dir(input logic [7:0] v);
        @(negedge clk);
        dir_we = 1'b1;
        dir_wdata = v;
        @(negedge clk);
        dir_we = 1'b0;
        dir_wdata = 8'h00;
        settle();
    endtask

    task automatic t_reset();
        exp_en = 1'b0;
        clk_src = 1'b1;
        do_reset(2'd1);
        check("R1 mode1 oe", pad_oe, 8'h40);
        check("R1 mode1 out", pad_out, 8'h40);
        do_reset(2'd2);
        check("R1 mode2 oe", pad_oe, 8'h00);
        do_reset(2'd3);
        check("R1 mode3 oe", pad_oe, 8'h00);
    endtask

    task automatic t_single();
        exp_en = 1'b0;
        port_dout = 8'h3C;
        clk_src = 1'b0;
        write_dir(8'hA5);
        check("R2 oe A5", pad_oe, 8'hA5);
        check("R3 out A5", pad_out, 8'h24);
        write_dir(8'hFF);
        check("R2 oe FF", pad_oe, 8'hFF);
        check("R3 out clk0", pad_out, 8'h3C);
        clk_src = 1'b1; settle();
        check("R3 out clk1", pad_out, 8'h7C);
        wait_mode = 2'b01; pad_in = 8'h80; settle();
        check("R7 single-chip pin7 oe", pad_oe, 8'hFF);
        check("R9 single-chip wait_req", {7'd0, wait_req}, 8'h00);
        wait_mode = 2'b10; i2c_sda_low = 1'b0; settle();
        check("R7 single-chip sda ignored", pad_oe, 8'hFF);
        wait_mode = 2'b00;
    endtask

    task automatic t_expanded();
        exp_en = 1'b1;
        bus_wide = 1'b0;
        wait_mode = 2'b00;
        bus_strobe = 4'b1010;
        port_dout = 8'hFF;
        write_dir(8'h00);
        check("R4 R5 oe narrow", pad_oe, 8'h39);
        check("R4 R5 out narrow", pad_out, 8'h28);
        bus_strobe = 4'b0101; settle();
        check("R4 R5 out strobe flip", pad_out, 8'h11);
        bus_wide = 1'b1;
        bus_strobe = 4'b1010;
        port_dout = 8'h02;
        write_dir(8'h07);
        check("R5 R6 oe wide", pad_oe, 8'h3F);
        check("R5 R6 out wide", pad_out, 8'h2A);
        clk_src = 1'b1;
        write_dir(8'h40);
        check("R6 pin6 clock expanded", pad_oe, 8'h78);
        check("R6 pin6 clock value", pad_out, 8'h68);
    endtask

    task automatic t_pin7();
        exp_en = 1'b1;
        bus_wide = 1'b1;
        bus_strobe = 4'b0000;
        port_dout = 8'h80;
        write_dir(8'h80);
        wait_mode = 2'b00; settle();
        check("R7 wm00 gpio oe", pad_oe, 8'hB8);
        check("R7 wm00 gpio out", pad_out, 8'h80);
        wait_mode = 2'b11; settle();
        check("R7 wm11 gpio oe", pad_oe, 8'hB8);
        wait_mode = 2'b01; pad_in = 8'h80; settle();
        check("R9 wait oe off", pad_oe, 8'h38);
        check("R9 wait_req high", {7'd0, wait_req}, 8'h01);
        pad_in = 8'h00; settle();
        check("R9 wait_req low", {7'd0, wait_req}, 8'h00);
        wait_mode = 2'b10; i2c_sda_low = 1'b1; settle();
        check("R8 sda low oe", pad_oe, 8'hB8);
        check("R8 sda low out", pad_out, 8'h00);
        i2c_sda_low = 1'b0; settle();
        check("R8 sda release oe", pad_oe, 8'h38);
        check("R9 no wait in sda", {7'd0, wait_req}, 8'h00);
        wait_mode = 2'b00;
    endtask

    task automatic t_readback();
        exp_en = 1'b0;
        port_dout = 8'h55;
        pad_in = 8'hAA;
        write_dir(8'h0F);
        check("R10 single-chip", port_rdata, 8'hA5);
        exp_en = 1'b1;
        bus_wide = 1'b0;
        wait_mode = 2'b00;
        clk_src = 1'b0;
        port_dout = 8'h00;
        pad_in = 8'hFF;
        write_dir(8'hFF);
        check("R10 expanded", port_rdata, 8'h79);
        wait_mode = 2'b10;
        pad_in = 8'h80; settle();
        check("R10 sda reads pad", port_rdata, 8'h80);
        wait_mode = 2'b00;
    endtask

    task automatic t_ignore();
        exp_en = 1'b0;
        do_reset(2'd2);
        @(negedge clk);
        mode_sel = 2'd1;
        dir_wdata = 8'hFF;
        repeat (3) @(negedge clk);
        settle();
        check("R11 mode change no reset", pad_oe, 8'h00);
        dir_wdata = 8'h00;
        do_reset(2'd1);
        @(negedge clk);
        mode_sel = 2'd3;
        repeat (2) @(negedge clk);
        settle();
        check("R11 mode1 value kept", pad_oe, 8'h40);
    endtask

    initial begin
        rst_n = 1'b0; mode_sel = 2'd2; exp_en = 1'b0; bus_wide = 1'b0;
        wait_mode = 2'b00; dir_we = 1'b0; dir_wdata = 8'h00;
        port_dout = 8'h00; clk_src = 1'b0; bus_strobe = 4'b0000;
        i2c_sda_low = 1'b0; pad_in = 8'h00;
        t_reset();
        t_single();
        t_expanded();
        t_pin7();
        t_readback();
        t_ignore();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule